// File: doc/BRIEF.md
# Multi-Context Memory Array Controller

This block is a word-addressable memory that holds one active context and `NUM_CTX` dormant backup contexts, all modelled as register arrays. Ordinary read and write requests reach only the active array. Two bulk commands move data between the active array and a chosen backup. A save copies the active array into backup `i` and leaves the active array as it was. A restore copies backup `i` into the active array and replaces what the active array held before.

Each bulk copy moves one word per clock, from address 0 up to `DEPTH-1`, and normal traffic waits until the copy ends. Every backup has a freshness flag. A save sets the flag and an age counter clears it once the retention interval has run out. A restore from a stale backup still copies, but it also raises an error pulse. A bulk command that names a context outside the range is refused with its own error pulse.

The controller has three states: `ST_IDLE`, `ST_SAVE` and `ST_RESTORE`. The transitions are:
- `ST_IDLE` → `ST_SAVE` on an accepted save with an in-range index.
- `ST_IDLE` → `ST_RESTORE` on an accepted restore with an in-range index.
- `ST_SAVE` → `ST_IDLE` and `ST_RESTORE` → `ST_IDLE` when the copy index reaches `DEPTH-1`.
- In every other case the state holds.

Top module: `mctx_mem`

## Requirements
- R1: Opcodes on `req_op` are 2'b00 read, 2'b01 write, 2'b10 save, 2'b11 restore. An accepted read (`req_valid` and `req_ready` both high at a clock edge) returns the active word at `req_addr` on `rd_data`, with `rd_valid` high for one cycle, in the cycle after acceptance.
- R2: An accepted write changes only the addressed word of the active array.
- R3: An accepted save to context i copies every active word into backup i and leaves the active array unchanged. `busy` is high for exactly `DEPTH` cycles.
- R4: While `busy` is high, `req_ready` is low, and a pending request is held and serviced only after the copy ends.
- R5: An accepted restore from context i overwrites the whole active array with backup i and keeps `busy` high for exactly `DEPTH` cycles.
- R6: Reads and writes never change any backup array.
- R7: `ctx_valid[i]` is set at the clock edge that completes a save to context i. It is clear after reset.
- R8: `ctx_valid[i]` stays high for exactly `RETENTION_CYCLES` cycles after it is set and then clears. If a save to i completes in the same cycle the flag would expire, the flag stays set and the interval starts again.
- R9: A restore from a context whose flag is clear still performs the copy. It also pulses `err_stale` for one cycle, in the cycle after acceptance.
- R10: A save or restore with `req_ctx >= NUM_CTX` pulses `err_ctx` in the cycle after acceptance. It starts no copy, leaves `busy` low and changes no memory.
- R11: After reset, `req_ready` is 1 and `busy`, `rd_valid`, `err_ctx`, `err_stale` and all of `ctx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | Opcode |
| req_addr | input | ADDR_W | Word address in the active array |
| req_wdata | input | DATA_W | Write data |
| req_ctx | input | CTX_W | Backup context index for save/restore |
| rd_data | output | DATA_W | Read data |
| rd_valid | output | 1 | Read data valid pulse |
| busy | output | 1 | Bulk copy in progress |
| err_ctx | output | 1 | Out-of-range context pulse |
| err_stale | output | 1 | Restore from stale context pulse |
| ctx_valid | output | NUM_CTX | Per-context freshness flags |

## Verification
Two functions can fall in the same cycle: the completion of a save to a context, and that context's retention expiry. The bench provokes this by timing a second save so that its last word lands on the edge where the first save's interval runs out. It then checks that the flag never drops and that it lasts a full fresh interval afterwards. A read request presented during a copy is a second collision. The bench checks that no read data appears while `busy` is high, and that the held read returns correct data once the copy ends.

// File: rtl/mctx_pkg.sv
package mctx_pkg;

    typedef enum logic [1:0] {
        OP_READ    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_SAVE    = 2'b10,
        OP_RESTORE = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_SAVE    = 2'b01,
        ST_RESTORE = 2'b10
    } state_e;

endpackage

// File: rtl/mctx_ctrl.sv
module mctx_ctrl
    import mctx_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic [NUM_CTX-1:0] ctx_valid,
    output logic               req_ready,
    output logic               busy,
    output logic               rd_en,
    output logic               wr_en,
    output logic               save_en,
    output logic               restore_en,
    output logic               copy_last,
    output logic [ADDR_W-1:0]  copy_idx,
    output logic [CTX_W-1:0]   copy_ctx,
    output logic               err_ctx,
    output logic               err_stale
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

    state_e            state_q, state_d;
    logic [ADDR_W-1:0] idx_q;
    logic [CTX_W-1:0]  ctx_q;
    logic              err_ctx_q, err_stale_q;

    op_e  op;
    logic accept, is_bulk, ctx_bad, ctx_fresh, start_copy;

    assign op      = op_e'(req_op);
    assign ctx_bad = (int'(req_ctx) >= NUM_CTX);

    always_comb begin
        ctx_fresh = 1'b0;
        for (int k = 0; k < NUM_CTX; k++) begin
            if (int'(req_ctx) == k) ctx_fresh = ctx_valid[k];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_copy) state_d = (op == OP_SAVE) ? ST_SAVE : ST_RESTORE;
            end
            ST_SAVE, ST_RESTORE: begin
                if (idx_q == LAST_IDX) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        save_en    = 1'b0;
        restore_en = 1'b0;
        unique case (state_q)
            ST_IDLE:    req_ready  = 1'b1;
            ST_SAVE:    save_en    = 1'b1;
            ST_RESTORE: restore_en = 1'b1;
            default:    req_ready  = 1'b0;
        endcase
        busy       = save_en | restore_en;
        accept     = req_valid & req_ready;
        is_bulk    = req_op[1];
        start_copy = accept & is_bulk & ~ctx_bad;
        rd_en      = accept & (op == OP_READ);
        wr_en      = accept & (op == OP_WRITE);
        copy_last  = busy & (idx_q == LAST_IDX);
        copy_idx   = idx_q;
        copy_ctx   = ctx_q;
        err_ctx    = err_ctx_q;
        err_stale  = err_stale_q;
    end

    // Copy index, latched context, error pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            ctx_q       <= '0;
            err_ctx_q   <= 1'b0;
            err_stale_q <= 1'b0;
        end else begin
            err_ctx_q   <= accept & is_bulk & ctx_bad;
            err_stale_q <= start_copy & (op == OP_RESTORE) & ~ctx_fresh;
            if (start_copy) begin
                idx_q <= '0;
                ctx_q <= req_ctx;
            end else if (busy) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mctx_active_ram.sv
module mctx_active_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              restore_en,
    input  logic [ADDR_W-1:0] copy_idx,
    input  logic [DATA_W-1:0] restore_data,
    output logic [DATA_W-1:0] copy_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              we;
    logic [ADDR_W-1:0] waddr;
    logic [DATA_W-1:0] wdata;

    always_comb begin
        we    = wr_en | restore_en;
        waddr = restore_en ? copy_idx : req_addr;
        wdata = restore_en ? restore_data : req_wdata;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign copy_data = mem[copy_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= mem[req_addr];
        end
    end

endmodule

// File: rtl/mctx_backup_bank.sv
module mctx_backup_bank #(
    parameter int ADDR_W           = 4,
    parameter int DATA_W           = 16,
    parameter int RETENTION_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              save_we,
    input  logic              save_last,
    input  logic [ADDR_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              fresh
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int AGE_W = $clog2(RETENTION_CYCLES + 1);
    localparam logic [AGE_W-1:0] AGE_END = AGE_W'(RETENTION_CYCLES - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AGE_W-1:0]  age_q;

    always_ff @(posedge clk) begin
        if (save_we) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

    // A completing save has priority over expiry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh <= 1'b0;
            age_q <= '0;
        end else if (save_we && save_last) begin
            fresh <= 1'b1;
            age_q <= '0;
        end else if (fresh) begin
            if (age_q == AGE_END) begin
                fresh <= 1'b0;
                age_q <= '0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mctx_mem.sv
module mctx_mem
    import mctx_pkg::*;
#(
    parameter int ADDR_W           = 4,
    parameter int DATA_W           = 16,
    parameter int NUM_CTX          = 4,
    parameter int CTX_W            = 3,
    parameter int RETENTION_CYCLES = 1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [CTX_W-1:0]   req_ctx,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic               busy,
    output logic               err_ctx,
    output logic               err_stale,
    output logic [NUM_CTX-1:0] ctx_valid
);

    logic              rd_en, wr_en, save_en, restore_en, copy_last;
    logic [ADDR_W-1:0] copy_idx;
    logic [CTX_W-1:0]  copy_ctx;
    logic [DATA_W-1:0] copy_data, restore_data;
    logic [DATA_W-1:0] bank_rdata [NUM_CTX];

    mctx_ctrl #(.ADDR_W(ADDR_W), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_ctx(req_ctx), .ctx_valid(ctx_valid), .req_ready(req_ready),
        .busy(busy), .rd_en(rd_en), .wr_en(wr_en), .save_en(save_en),
        .restore_en(restore_en), .copy_last(copy_last), .copy_idx(copy_idx),
        .copy_ctx(copy_ctx), .err_ctx(err_ctx), .err_stale(err_stale)
    );

    mctx_active_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_active (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .req_addr(req_addr), .req_wdata(req_wdata), .restore_en(restore_en),
        .copy_idx(copy_idx), .restore_data(restore_data),
        .copy_data(copy_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_bank
        logic sel;
        assign sel = save_en & (int'(copy_ctx) == g);
        mctx_backup_bank #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RETENTION_CYCLES(RETENTION_CYCLES)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .save_we(sel), .save_last(copy_last),
            .idx(copy_idx), .wdata(copy_data), .rdata(bank_rdata[g]),
            .fresh(ctx_valid[g])
        );
    end

    always_comb begin
        restore_data = '0;
        for (int k = 0; k < NUM_CTX; k++) begin
            if (int'(copy_ctx) == k) restore_data = bank_rdata[k];
        end
    end

endmodule

// File: rtl/mctx_mem_chk.sv
module mctx_mem_chk #(
    parameter int ADDR_W  = 4,
    parameter int NUM_CTX = 4,
    parameter int CTX_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [1:0]         req_op,
    input logic [CTX_W-1:0]   req_ctx,
    input logic               rd_valid,
    input logic               busy,
    input logic               err_ctx,
    input logic               err_stale,
    input logic [NUM_CTX-1:0] ctx_valid
);

    // R4
    busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    // R1
    rd_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && req_ready && req_op == 2'b00));

    // R4
    no_read_in_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !$past(busy));

    // R10
    bad_ctx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_ctx |-> $past(req_valid && req_ready && req_op[1] && (int'(req_ctx) >= NUM_CTX)));

    // R10
    bad_ctx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_ctx |-> !busy);

    // R9
    stale_in_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_stale |-> busy);

    // R7
    fresh_set_by_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctx_valid & ~$past(ctx_valid)) != '0) |-> $past(busy));

endmodule

bind mctx_mem mctx_mem_chk #(.ADDR_W(ADDR_W), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_ctx(req_ctx), .rd_valid(rd_valid), .busy(busy),
    .err_ctx(err_ctx), .err_stale(err_stale), .ctx_valid(ctx_valid)
);

// File: tb/mctx_mem_bench.sv
module mctx_mem_bench;

    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 16;
    localparam int NUM_CTX = 2;
    localparam int CTX_W   = 3;
    localparam int RET     = 40;
    localparam int DEPTH   = 1 << ADDR_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [1:0]         req_op = '0;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic [CTX_W-1:0]   req_ctx = '0;
    logic [DATA_W-1:0]  rd_data;
    logic               rd_valid, busy, err_ctx, err_stale;
    logic [NUM_CTX-1:0] ctx_valid;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    mctx_mem #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTX(NUM_CTX),
        .CTX_W(CTX_W), .RETENTION_CYCLES(RET)
    ) u_mctx_mem (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ctx(req_ctx), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .err_ctx(err_ctx), .err_stale(err_stale), .ctx_valid(ctx_valid)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  addr;
        logic [15:0] wd;
        logic [2:0]  ctx;
        logic        chk_rd;
        logic [15:0] exp_rd;
        logic        exp_ectx;
        logic        exp_stale;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{2'd1, 3'd0, 16'h1111, 3'd0, 1'b0, 16'h0000, 1'b0, 1'b0},  // write a0
        '{2'd1, 3'd5, 16'h5555, 3'd0, 1'b0, 16'h0000, 1'b0, 1'b0},  // write a5
        '{2'd0, 3'd0, 16'h0000, 3'd0, 1'b1, 16'h1111, 1'b0, 1'b0},  // R2 a0 untouched
        '{2'd2, 3'd0, 16'h0000, 3'd0, 1'b0, 16'h0000, 1'b0, 1'b0},  // save ctx0
        '{2'd0, 3'd5, 16'h0000, 3'd0, 1'b1, 16'h5555, 1'b0, 1'b0},  // R3 active kept
        '{2'd1, 3'd0, 16'hAAAA, 3'd0, 1'b0, 16'h0000, 1'b0, 1'b0},  // overwrite a0
        '{2'd0, 3'd0, 16'h0000, 3'd0, 1'b1, 16'hAAAA, 1'b0, 1'b0},
        '{2'd3, 3'd0, 16'h0000, 3'd0, 1'b0, 16'h0000, 1'b0, 1'b0},  // restore ctx0
        '{2'd0, 3'd0, 16'h0000, 3'd0, 1'b1, 16'h1111, 1'b0, 1'b0},  // R5 R6
        '{2'd3, 3'd0, 16'h0000, 3'd1, 1'b0, 16'h0000, 1'b0, 1'b1},  // R9 stale ctx1
        '{2'd1, 3'd0, 16'h2222, 3'd0, 1'b0, 16'h0000, 1'b0, 1'b0},
        '{2'd2, 3'd0, 16'h0000, 3'd2, 1'b0, 16'h0000, 1'b1, 1'b0},  // R10 idx 2
        '{2'd3, 3'd0, 16'h0000, 3'd7, 1'b0, 16'h0000, 1'b1, 1'b0},  // R10 idx 7
        '{2'd0, 3'd0, 16'h0000, 3'd0, 1'b1, 16'h2222, 1'b0, 1'b0}   // R10 nothing changed
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after acceptance.
    task automatic do_req(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input logic [CTX_W-1:0] c);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = d;
        req_ctx   = c;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic measure_fresh(input int k, output int cycles);
        cycles = 0;
        while (ctx_valid[k] && cycles < 10 * RET) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        int nb;
        int life;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(req_ready == 1'b1, "R11 ready", 32'(req_ready), 32'd1);
        check({busy, rd_valid, err_ctx, err_stale} == 4'b0, "R11 flags",
              32'({busy, rd_valid, err_ctx, err_stale}), 32'd0);
        check(ctx_valid == '0, "R11 R7 ctx_valid", 32'(ctx_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = TBL[i];
            do_req(v.op, v.addr, v.wd, v.ctx);
            if (v.chk_rd) begin
                check(rd_valid == 1'b1, "R1 rd_valid", 32'(rd_valid), 32'd1);
                check(rd_data == v.exp_rd, "R1 rd_data", 32'(rd_data), 32'(v.exp_rd));
            end
            check(err_ctx == v.exp_ectx, "R10 err_ctx", 32'(err_ctx), 32'(v.exp_ectx));
            check(err_stale == v.exp_stale, "R9 err_stale", 32'(err_stale), 32'(v.exp_stale));
            if (v.op[1] && !v.exp_ectx) begin
                wait_idle(nb);
                check(nb == DEPTH, "R3 R5 busy length", 32'(nb), 32'(DEPTH));
            end else begin
                check(busy == 1'b0, "R10 no copy", 32'(busy), 32'd0);
            end
            if (i == 3) check(ctx_valid[0] == 1'b1, "R7 set by save", 32'(ctx_valid[0]), 32'd1);
        end

        // R4: read presented during a copy is held, then served
        do_req(2'd1, 3'd3, 16'h3333, 3'd0);
        do_req(2'd2, 3'd0, 16'h0000, 3'd1);
        req_valid = 1'b1;
        req_op    = 2'd0;
        req_addr  = 3'd3;
        while (busy) begin
            check(req_ready == 1'b0 && rd_valid == 1'b0, "R4 stall",
                  32'({req_ready, rd_valid}), 32'd0);
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(rd_valid == 1'b1 && rd_data == 16'h3333, "R4 held read",
              32'(rd_data), 32'h3333);
        check(ctx_valid[1] == 1'b1, "R7 ctx1 set", 32'(ctx_valid[1]), 32'd1);

        // R8 retention length
        do_req(2'd2, 3'd0, 16'h0000, 3'd1);
        wait_idle(nb);
        measure_fresh(1, life);
        check(life == RET, "R8 retention", 32'(life), 32'(RET));
        do_req(2'd3, 3'd0, 16'h0000, 3'd1);
        check(err_stale == 1'b1, "R9 expired restore", 32'(err_stale), 32'd1);
        wait_idle(nb);

        // R8 save completing on the expiry edge
        do_req(2'd2, 3'd0, 16'h0000, 3'd1);
        wait_idle(nb);
        repeat (RET - DEPTH - 1) @(negedge clk);
        do_req(2'd2, 3'd0, 16'h0000, 3'd1);
        wait_idle(nb);
        check(ctx_valid[1] == 1'b1, "R8 coincident save", 32'(ctx_valid[1]), 32'd1);
        measure_fresh(1, life);
        check(life == RET, "R8 restarted interval", 32'(life), 32'(RET));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule